// File: doc/BRIEF.md
# Exact FP32 Sum Accumulator

This block sums a stream of IEEE single-precision operands with no rounding at all. Each finite operand is split into its sign, its integer significand and its exponent. The significand is then moved to its place in a wide two's-complement fixed-point register and added or subtracted. The register's least significant bit weighs 2^-149, which is the smallest subnormal. Every finite operand is therefore an exact integer multiple of that unit. Integer addition is associative, so the register contents after any ordering of the same operand set are bit-identical.

Values that cannot be expressed in fixed point never reach the register. NaN, the two infinities and zeros update sticky sideband flags instead. A pair of opposite infinities also raises an invalid flag. The register has carry headroom for a configurable maximum participant count. A consumer reads the raw wide sum and the flags. Turning the sum back into a floating-point number happens downstream.

A one-cycle clear pulse starts a new reduction. Operands are offered with a valid/ready handshake, and one is taken in every cycle that ready is high.

Top module: `sacc_fp32_top`

## Requirements
- R1: After reset the sum is zero, every flag is low, and ready is high.
- R2: An accepted operand (sign bit 31, exponent field bits 30:23, fraction field bits 22:0) with exponent field E in 1..254 and fraction F changes the sum by (2^23 + F) * 2^(E-1) units of 2^-149 in the cycle after acceptance.
- R3: An accepted operand with E = 0 and F nonzero (subnormal) changes the sum by exactly F units.
- R4: When bit 31 is set, the magnitude given by R2/R3 is subtracted instead of added, in two's complement.
- R5: The final sum of a set of finite operands is identical for every order in which the set is delivered.
- R6: The register is 278 + ceil(log2 MAX_PARTS) bits wide (286 by default). MAX_PARTS same-sign maximum-magnitude finite operands accumulate without wrapping.
- R7: An operand with E = 255 and F nonzero (NaN) sets the NaN flag and leaves the sum unchanged.
- R8: E = 255 with F = 0 sets the positive- or negative-infinity flag according to bit 31, and the sum is unchanged. Once both infinity flags are set, the invalid flag is set as well.
- R9: A zero operand (E = 0, F = 0) leaves the sum unchanged and sets the zero-seen flag. The negative-zero flag is high only if every zero accepted since the last clear had bit 31 set.
- R10: A clear pulse zeroes the sum and every flag in the next cycle. While clear is high, ready is low and any offered operand is not taken.
- R11: Ready stays high when clear is low, so operands offered on consecutive cycles are each accepted, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Start a new reduction (zero sum and flags) |
| in_valid_i | input | 1 | Operand offered |
| in_ready_o | output | 1 | Operand can be accepted this cycle |
| in_data_i | input | 32 | FP32 operand bits |
| sum_o | output | 278+clog2(MAX_PARTS) | Exact two's-complement sum, LSB weight 2^-149 |
| nan_o | output | 1 | A NaN was accepted |
| pos_inf_o | output | 1 | A positive infinity was accepted |
| neg_inf_o | output | 1 | A negative infinity was accepted |
| invalid_o | output | 1 | Infinities of both signs were accepted |
| zero_seen_o | output | 1 | At least one zero was accepted |
| zero_neg_o | output | 1 | Every zero accepted was negative |

## Verification
Clear and deposit can coincide: a clear pulse may arrive in the same cycle that a valid operand is offered. The bench provokes this after building up a nonzero sum and raised flags. It then offers a 1.0 together with the clear pulse. On the next cycle the sum and every flag must be zero, and ready must have been low during the pulse, so the colliding operand never entered the register. The exponent sweep adds and then subtracts an operand at every exponent. Each intermediate sum is compared with a value the bench computes by repeated doubling.

// File: rtl/sacc_pkg.sv
package sacc_pkg;
    localparam int FP_W     = 32;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int EXP_ALL1 = (1 << EXP_W) - 1;
    localparam int SHIFT_W  = EXP_W;
    // magnitude bits of the largest finite operand at 2^-149 resolution
    localparam int MAG_W    = SIG_W + EXP_ALL1 - 2;

    typedef enum logic [2:0] {
        K_ZERO = 3'd0,
        K_SUB  = 3'd1,
        K_NORM = 3'd2,
        K_INF  = 3'd3,
        K_NAN  = 3'd4
    } kind_e;

    typedef struct packed {
        logic                neg;
        kind_e               kind;
        logic [SIG_W-1:0]    sig;
        logic [SHIFT_W-1:0]  shift;
    } opnd_t;
endpackage

// File: rtl/sacc_unpack.sv
module sacc_unpack
    import sacc_pkg::*;
(
    input  logic [FP_W-1:0] bits_i,
    output opnd_t           opnd_o
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f        = bits_i[FP_W-2 -: EXP_W];
        frac_f       = bits_i[FRAC_W-1:0];
        opnd_o.neg   = bits_i[FP_W-1];
        opnd_o.sig   = '0;
        opnd_o.shift = '0;
        if (exp_f == '0) begin
            opnd_o.kind = (frac_f == '0) ? K_ZERO : K_SUB;
            opnd_o.sig  = {1'b0, frac_f};
        end else if (exp_f == EXP_W'(EXP_ALL1)) begin
            opnd_o.kind = (frac_f == '0) ? K_INF : K_NAN;
        end else begin
            opnd_o.kind  = K_NORM;
            opnd_o.sig   = {1'b1, frac_f};
            opnd_o.shift = exp_f - SHIFT_W'(1);
        end
    end
endmodule

// File: rtl/sacc_align.sv
module sacc_align
    import sacc_pkg::*;
#(
    parameter int ACC_W = MAG_W + 9
)(
    input  opnd_t             opnd_i,
    output logic [ACC_W-1:0]  term_o
);
    localparam int PAD_W = ACC_W - SIG_W;

    logic [ACC_W-1:0] mag;
    logic             finite_nz;

    always_comb begin
        finite_nz = (opnd_i.kind == K_SUB) || (opnd_i.kind == K_NORM);
        mag       = '0;
        if (finite_nz) begin
            mag = {{PAD_W{1'b0}}, opnd_i.sig} << opnd_i.shift;
        end
        term_o = opnd_i.neg ? (~mag + ACC_W'(1)) : mag;
    end
endmodule

// File: rtl/sacc_flags.sv
module sacc_flags
    import sacc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear_i,
    input  logic  take_i,
    input  opnd_t opnd_i,
    output logic  nan_o,
    output logic  pos_inf_o,
    output logic  neg_inf_o,
    output logic  invalid_o,
    output logic  zero_seen_o,
    output logic  zero_neg_o
);
    typedef struct packed {
        logic nan;
        logic pinf;
        logic ninf;
        logic invalid;
        logic zseen;
        logic zneg;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (take_i) begin
            unique case (opnd_i.kind)
                K_NAN: st_d.nan = 1'b1;
                K_INF: begin
                    if (opnd_i.neg) st_d.ninf = 1'b1;
                    else            st_d.pinf = 1'b1;
                end
                K_ZERO: begin
                    st_d.zneg  = st_q.zseen ? (st_q.zneg & opnd_i.neg) : opnd_i.neg;
                    st_d.zseen = 1'b1;
                end
                default: ;
            endcase
            st_d.invalid = st_q.invalid | (st_d.pinf & st_d.ninf);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nan_o       = st_q.nan;
    assign pos_inf_o   = st_q.pinf;
    assign neg_inf_o   = st_q.ninf;
    assign invalid_o   = st_q.invalid;
    assign zero_seen_o = st_q.zseen;
    assign zero_neg_o  = st_q.zneg;

    AST_ZNEG_NEEDS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.zneg |-> st_q.zseen);  // R9
    AST_NAN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.nan && !clear_i) |=> st_q.nan);  // R7
    AST_INVALID_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pinf && st_q.ninf) |-> st_q.invalid);  // R8
endmodule

// File: rtl/sacc_fp32_top.sv
module sacc_fp32_top
    import sacc_pkg::*;
#(
    parameter int MAX_PARTS = 256
)(
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clear_i,
    input  logic                                  in_valid_i,
    output logic                                  in_ready_o,
    input  logic [31:0]                           in_data_i,
    output logic [MAG_W+$clog2(MAX_PARTS):0]      sum_o,
    output logic                                  nan_o,
    output logic                                  pos_inf_o,
    output logic                                  neg_inf_o,
    output logic                                  invalid_o,
    output logic                                  zero_seen_o,
    output logic                                  zero_neg_o
);
    localparam int HEAD_W = $clog2(MAX_PARTS);
    localparam int ACC_W  = MAG_W + HEAD_W + 1;

    opnd_t            opnd;
    logic [ACC_W-1:0] term;
    logic             take;
    logic [ACC_W-1:0] sum_d, sum_q;

    sacc_unpack u_unpack (
        .bits_i (in_data_i),
        .opnd_o (opnd)
    );

    sacc_align #(.ACC_W(ACC_W)) u_align (
        .opnd_i (opnd),
        .term_o (term)
    );

    assign in_ready_o = ~clear_i;
    assign take       = in_valid_i & in_ready_o;

    always_comb begin
        sum_d = sum_q;
        if (clear_i)   sum_d = '0;
        else if (take) sum_d = sum_q + term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum_o = sum_q;

    sacc_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear_i),
        .take_i      (take),
        .opnd_i      (opnd),
        .nan_o       (nan_o),
        .pos_inf_o   (pos_inf_o),
        .neg_inf_o   (neg_inf_o),
        .invalid_o   (invalid_o),
        .zero_seen_o (zero_seen_o),
        .zero_neg_o  (zero_neg_o)
    );

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (sum_o == '0 && !nan_o && !pos_inf_o && !neg_inf_o
                     && !invalid_o && !zero_seen_o && !zero_neg_o));  // R10
    AST_SPECIAL_NO_DEPOSIT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (opnd.kind == K_NAN || opnd.kind == K_INF || opnd.kind == K_ZERO))
        |=> $stable(sum_o));  // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid_i && !clear_i) |=> $stable(sum_o));  // R11
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (opnd.kind == K_NORM || opnd.kind == K_SUB)
         && (sum_o[ACC_W-1] == opnd.neg) && (sum_o != '0))
        |=> (sum_o[ACC_W-1] == $past(opnd.neg)));  // R6
endmodule

// File: tb/sacc_fp32_top_tb.sv
module sacc_fp32_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PARTS      = 256;
    localparam int AW         = 278 + $clog2(PARTS);
    localparam int WD_CYCLES  = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          vld = 1'b0;
    logic [31:0]   data = '0;
    logic          rdy;
    logic [AW-1:0] sum;
    logic          f_nan, f_pinf, f_ninf, f_inv, f_zs, f_zn;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sacc_fp32_top #(.MAX_PARTS(PARTS)) dut_i (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .in_valid_i(vld),
        .in_ready_o(rdy), .in_data_i(data), .sum_o(sum), .nan_o(f_nan),
        .pos_inf_o(f_pinf), .neg_inf_o(f_ninf), .invalid_o(f_inv),
        .zero_seen_o(f_zs), .zero_neg_o(f_zn)
    );

    // exact value in units of 2^-149, by repeated doubling
    function automatic logic [AW-1:0] ref_val(input logic [31:0] b);
        int e = int'(b[30:23]);
        logic [AW-1:0] m;
        if (e == 255) return '0;
        m = AW'(b[22:0]);
        if (e != 0) m = m + (AW'(1) << 23);
        for (int i = 1; i < e; i++) m = m + m;
        if (b[31]) m = '0 - m;
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] b);
        @(negedge clk); vld = 1'b1; data = b;
        @(negedge clk); vld = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1'b1;
        #1 chk(rdy == 1'b0, "R10 ready low in clear", AW'(rdy), '0);
        @(negedge clk); clear = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    logic [31:0] set8 [8];
    logic [31:0] op;
    logic [AW-1:0] acc_exp;

    initial begin
        set8[0] = 32'h3F800000; set8[1] = 32'hC0490FDB;
        set8[2] = 32'h00000007; set8[3] = 32'h7F000001;
        set8[4] = 32'hFF000001; set8[5] = 32'h33800000;
        set8[6] = 32'h80000123; set8[7] = 32'h4B7FFFFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(sum == '0 && !f_nan && !f_pinf && !f_ninf && !f_inv && !f_zs && !f_zn,
            "R1 reset sum/flags", sum, '0);
        chk(rdy == 1'b1, "R1 ready after reset", AW'(rdy), AW'(1));

        // R2 R3 R4: sweep every finite exponent
        for (int e = 0; e < 255; e++) begin
            logic [22:0] fr;
            fr = 23'(((e * 32'h9E3779B1) >> 9) ^ e) | 23'd1;
            op = {1'b0, 8'(e), fr};
            do_clear();
            send(op);
            chk(sum == ref_val(op), (e == 0) ? "R3 subnormal deposit" : "R2 normal deposit",
                sum, ref_val(op));
            send({1'b1, op[30:0]});
            chk(sum == '0, "R4 negative cancels", sum, '0);
        end
        do_clear();
        send(32'h80000005);
        chk(sum == ('0 - AW'(5)), "R4 negative subnormal", sum, '0 - AW'(5));

        // R5 R11: three orderings streamed back-to-back
        acc_exp = '0;
        for (int i = 0; i < 8; i++) acc_exp = acc_exp + ref_val(set8[i]);
        for (int k = 0; k < 3; k++) begin
            do_clear();
            @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                int j;
                j = (k == 0) ? i : (k == 1) ? 7 - i : (i * 3) % 8;
                vld = 1'b1; data = set8[j];
                #1 chk(rdy == 1'b1, "R11 ready in stream", AW'(rdy), AW'(1));
                @(negedge clk);
            end
            vld = 1'b0;
            chk(sum == acc_exp, "R5 order independent sum", sum, acc_exp);
        end

        // R6: headroom for PARTS max-magnitude operands
        do_clear();
        @(negedge clk);
        for (int i = 0; i < PARTS; i++) begin
            vld = 1'b1; data = 32'h7F7FFFFF; @(negedge clk);
        end
        vld = 1'b0;
        acc_exp = '0;
        for (int i = 0; i < PARTS; i++) acc_exp = acc_exp + ref_val(32'h7F7FFFFF);
        chk(sum == acc_exp && !sum[AW-1], "R6 positive headroom", sum, acc_exp);
        do_clear();
        @(negedge clk);
        for (int i = 0; i < PARTS; i++) begin
            vld = 1'b1; data = 32'hFF7FFFFF; @(negedge clk);
        end
        vld = 1'b0;
        chk(sum == ('0 - acc_exp) && sum[AW-1], "R6 negative headroom", sum, '0 - acc_exp);

        // R7 NaN
        do_clear();
        send(32'h40000000);
        send(32'h7FC00001);
        chk(f_nan && sum == ref_val(32'h40000000), "R7 NaN flag, sum held", sum,
            ref_val(32'h40000000));
        // R8 infinities
        send(32'h7F800000);
        chk(f_pinf && !f_ninf && !f_inv && sum == ref_val(32'h40000000),
            "R8 +inf flag only", sum, ref_val(32'h40000000));
        send(32'hFF800000);
        chk(f_pinf && f_ninf && f_inv && sum == ref_val(32'h40000000),
            "R8 opposite infinities invalid", {f_pinf, f_ninf, f_inv}, 3'b111);
        // R9 zeros
        do_clear();
        send(32'h80000000);
        chk(f_zs && f_zn && sum == '0, "R9 negative zero only", {f_zs, f_zn}, 2'b11);
        send(32'h80000000);
        chk(f_zs && f_zn, "R9 two negative zeros", {f_zs, f_zn}, 2'b11);
        send(32'h00000000);
        chk(f_zs && !f_zn && sum == '0, "R9 mixed zeros", {f_zs, f_zn}, 2'b10);
        send(32'h3F800000);
        send(32'h80000000);
        chk(!f_zn && sum == ref_val(32'h3F800000), "R9 zero leaves sum", sum,
            ref_val(32'h3F800000));

        // R10 clear colliding with an offered operand
        send(32'h7FC00000);
        send(32'h7F800000);
        @(negedge clk); clear = 1'b1; vld = 1'b1; data = 32'h3F800000;
        #1 chk(rdy == 1'b0, "R10 ready low on collision", AW'(rdy), '0);
        @(negedge clk); clear = 1'b0; vld = 1'b0;
        chk(sum == '0 && !f_nan && !f_pinf && !f_ninf && !f_inv && !f_zs && !f_zn,
            "R10 clear wins over deposit", sum, '0);
        @(negedge clk);
        chk(sum == '0, "R10 colliding operand dropped", sum, '0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule